// File: doc/BRIEF.md
# SD card command path controller

This block drives the bidirectional command line of an SD/MMC-style card. A host-side sequencer issues one command at a time: a 6-bit command index, a 32-bit argument and two flags that say whether the card answers and whether the answer is long or short. The block sends the command as a 48-bit serial frame, one bit per clock. It then releases the line, waits for the card's start bit, captures the response and checks it. After every command it holds the line high for a fixed gap before it accepts the next one. The first command after reset is preceded by the power-up clock sequence. Clock division is done outside the block: each `clk` cycle is one bit time on the line.

Commands come in on a valid/ready pair. `cmd_ready` is high only while the controller is idle. A command is taken on any clock edge where `cmd_valid` and `cmd_ready` are both high, and its fields are captured on that edge. While `cmd_ready` is low, `cmd_valid` may stay high and the fields may change without effect. The response side has no back-pressure. The received index and payload stay on their outputs until the next command is accepted. `resp_done` marks the cycle in which they become final.

The current controller state is driven on `fsm_state` as a fixed 4-bit code so that it can be read as status.

Top module: `sdcmd_path`

## Requirements
- R1: After reset, `fsm_state` is 0 (idle), `cmd_line_oe` is 0, `cmd_line_out` is 1, `cmd_ready` is 1, and `err_crc`, `err_timeout` and `resp_done` are 0.
- R2: `cmd_ready` is 1 exactly while `fsm_state` is 0. A command is accepted on an edge with `cmd_valid`=1 and `cmd_ready`=1, and its index, argument and flags are captured on that edge. Changing the inputs after acceptance has no effect on the frame or on the response checks.
- R3: The first command after reset spends 74 cycles in state 1 with `cmd_line_oe`=1 and `cmd_line_out`=1 before its start bit. Later commands go from state 0 directly to state 2.
- R4: The command frame is sent with `cmd_line_oe`=1 in this order: state 2 for 1 cycle with out=0; state 3 for 1 cycle with out=1; state 4 for 38 cycles carrying the index and then the argument, each MSB first; state 5 for 7 cycles carrying the CRC7, MSB first; state 6 for 1 cycle with out=1.
- R5: The frame CRC7 uses the polynomial x^7+x^3+1, starts from zero, and covers the first 40 frame bits (start bit through the last argument bit).
- R6: Every command ends in state 14: 8 cycles with `cmd_line_oe`=1 and out=1, then state 0. A command without a response goes from state 6 to state 14.
- R7: A command that expects a response goes from state 6 to state 15 with `cmd_line_oe`=0. A cycle in state 15 where `cmd_line_in` is 0 is the last cycle of state 15. The bit seen in that cycle is the response start bit, and it is consumed in state 7 in the next cycle. Every later response bit is consumed one cycle after it appears on `cmd_line_in`.
- R8: If `cmd_line_in` stays 1 for 64 cycles in state 15, `err_timeout` becomes 1 and the block moves to state 14. A start bit seen in the 64th cycle is still accepted as a response.
- R9: A short response passes through state 7 (1 cycle), state 9 (1), state 10 (6, the index echo into `resp_index`, MSB first), state 11 (32, into `resp_payload[31:0]`, MSB first, with the upper bits 0), state 12 (7, the received CRC7) and state 13 (1, the end bit).
- R10: A long response passes through states 7, 9, 10 (6 cycles) and 11 for 120 cycles into `resp_payload[119:0]`, then goes directly to state 13. Neither its CRC nor its index echo is checked.
- R11: `err_crc` becomes 1 when the end bit is 0, or when a short response has a CRC7 (computed over its first 40 bits) or an index echo that differs from what was expected. Both error flags stay set until the next command is accepted, which clears them.
- R12: `resp_done` is 1 for exactly the one cycle that follows state 13, which is the first cycle of state 14. At that point `resp_index`, `resp_payload` and `err_crc` are final.
- R13: State 8 (interrupt-type response) is a reserved code and is never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_resp_en | input | 1 | Card is expected to answer |
| cmd_resp_long | input | 1 | Answer is the 120-bit long form |
| cmd_line_in | input | 1 | Command line as seen from the card side |
| cmd_line_out | output | 1 | Command line value driven by the host |
| cmd_line_oe | output | 1 | Host drives the command line |
| resp_index | output | 6 | Received index echo |
| resp_payload | output | 120 | Received response payload |
| resp_done | output | 1 | One-cycle mark that the response is final |
| err_crc | output | 1 | Sticky response error (CRC, index echo or end bit) |
| err_timeout | output | 1 | Sticky missing-response flag |
| fsm_state | output | 4 | Current state code |

## Verification
On every cycle, the assertions check the following: the fixed successions inside the command frame, that an accepted command goes on to initialisation or to the start bit, that the reserved state 8 is never entered, that the error flags move only while the controller waits for or ends a response or accepts a command, and that a stopped CRC register holds its value. Timeouts are checked as well, since a timeout can only appear out of the turnaround wait. The bit-exact frame contents are shown only by the bench scenarios, which compare the full per-cycle trace of state, line value and enable against a model. These include the CRC value, the 74-cycle initialisation on the first command alone, the response field layout for both lengths, detection of the start bit at the first and at the 64th wait cycle, and each error source together with its clearing.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_INIT    = 4'd1,
    ST_TXSTART = 4'd2,
    ST_TXDIR   = 4'd3,
    ST_TXBODY  = 4'd4,
    ST_TXCRC   = 4'd5,
    ST_TXEND   = 4'd6,
    ST_RXSTART = 4'd7,
    ST_RXIRQ   = 4'd8,
    ST_RXDIR   = 4'd9,
    ST_RXIDX   = 4'd10,
    ST_RXDATA  = 4'd11,
    ST_RXCRC   = 4'd12,
    ST_RXEND   = 4'd13,
    ST_GAP     = 4'd14,
    ST_TURN    = 4'd15
  } sd_state_t;

  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = d ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= '0;
    else if (en)       crc <= crc7_step(crc, din);
  end

  // R5
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));

endmodule

// File: rtl/sdcmd_capture.sv
module sdcmd_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (en)       q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/sdcmd_path.sv
module sdcmd_path
  import sdcmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int SHORT_W   = 32,
  parameter int LONG_W    = 120,
  parameter int INIT_CLKS = 74,
  parameter int TURN_MAX  = 64,
  parameter int GAP_CLKS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              cmd_resp_en,
  input  logic              cmd_resp_long,
  input  logic              cmd_line_in,
  output logic              cmd_line_out,
  output logic              cmd_line_oe,
  output logic [IDX_W-1:0]  resp_index,
  output logic [LONG_W-1:0] resp_payload,
  output logic              resp_done,
  output logic              err_crc,
  output logic              err_timeout,
  output logic [3:0]        fsm_state
);

  localparam int BODY_W = IDX_W + ARG_W;
  localparam int M1     = (INIT_CLKS > LONG_W) ? INIT_CLKS : LONG_W;
  localparam int M2     = (TURN_MAX > BODY_W) ? TURN_MAX : BODY_W;
  localparam int MAXLEN = (M1 > M2) ? M1 : M2;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  sd_state_t          state, state_n;
  logic [CNT_W-1:0]   cnt;
  logic               init_done;
  logic [BODY_W-1:0]  body_sh;
  logic               want_resp, is_long;
  logic [IDX_W-1:0]   exp_idx;
  logic               line_q;
  logic               done_q, err_crc_q, err_to_q;
  logic [CRC_W-1:0]   tx_crc, rx_crc, rcv_crc;
  logic [2:0]         crc_pos;
  logic               accept, resp_bad, timed_out;

  function automatic logic hit(input logic [CNT_W-1:0] c, input int len);
    return c == CNT_W'(len - 1);
  endfunction

  assign accept  = cmd_valid && (state == ST_IDLE);
  assign crc_pos = 3'(CRC_W - 1) - cnt[2:0];

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:    if (accept) state_n = init_done ? ST_TXSTART : ST_INIT;
      ST_INIT:    if (hit(cnt, INIT_CLKS)) state_n = ST_TXSTART;
      ST_TXSTART: state_n = ST_TXDIR;
      ST_TXDIR:   state_n = ST_TXBODY;
      ST_TXBODY:  if (hit(cnt, BODY_W)) state_n = ST_TXCRC;
      ST_TXCRC:   if (hit(cnt, CRC_W)) state_n = ST_TXEND;
      ST_TXEND:   state_n = want_resp ? ST_TURN : ST_GAP;
      ST_TURN: begin
        if (!cmd_line_in)             state_n = ST_RXSTART;
        else if (hit(cnt, TURN_MAX))  state_n = ST_GAP;
      end
      ST_RXSTART: state_n = ST_RXDIR;
      ST_RXDIR:   state_n = ST_RXIDX;
      ST_RXIDX:   if (hit(cnt, IDX_W)) state_n = ST_RXDATA;
      ST_RXDATA: begin
        if (is_long && hit(cnt, LONG_W))        state_n = ST_RXEND;
        else if (!is_long && hit(cnt, SHORT_W)) state_n = ST_RXCRC;
      end
      ST_RXCRC:   if (hit(cnt, CRC_W)) state_n = ST_RXEND;
      ST_RXEND:   state_n = ST_GAP;
      ST_GAP:     if (hit(cnt, GAP_CLKS)) state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  assign timed_out = (state == ST_TURN) && cmd_line_in && hit(cnt, TURN_MAX);
  assign resp_bad  = !line_q || (!is_long && ((rcv_crc != rx_crc) || (resp_index != exp_idx)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      init_done <= 1'b0;
      body_sh   <= '0;
      want_resp <= 1'b0;
      is_long   <= 1'b0;
      exp_idx   <= '0;
      line_q    <= 1'b1;
      done_q    <= 1'b0;
      err_crc_q <= 1'b0;
      err_to_q  <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= (state_n != state) ? '0 : cnt + 1'b1;
      line_q <= cmd_line_in;
      done_q <= (state == ST_RXEND);
      if (state == ST_INIT && hit(cnt, INIT_CLKS)) init_done <= 1'b1;
      if (accept) begin
        body_sh   <= {cmd_index, cmd_arg};
        want_resp <= cmd_resp_en;
        is_long   <= cmd_resp_long;
        exp_idx   <= cmd_index;
        err_crc_q <= 1'b0;
        err_to_q  <= 1'b0;
      end else begin
        if (state == ST_TXBODY) body_sh <= {body_sh[BODY_W-2:0], 1'b0};
        if (state == ST_RXEND && resp_bad) err_crc_q <= 1'b1;
        if (timed_out) err_to_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd_line_oe  = 1'b0;
    cmd_line_out = 1'b1;
    case (state)
      ST_INIT, ST_TXDIR, ST_TXEND, ST_GAP: cmd_line_oe = 1'b1;
      ST_TXSTART: begin cmd_line_oe = 1'b1; cmd_line_out = 1'b0; end
      ST_TXBODY:  begin cmd_line_oe = 1'b1; cmd_line_out = body_sh[BODY_W-1]; end
      ST_TXCRC:   begin cmd_line_oe = 1'b1; cmd_line_out = tx_crc[crc_pos]; end
      default: ;
    endcase
  end

  sdcmd_crc7 u_tx_crc (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .en(state inside {ST_TXSTART, ST_TXDIR, ST_TXBODY}),
    .din(cmd_line_out), .crc(tx_crc)
  );

  sdcmd_crc7 u_rx_crc (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .en(state inside {ST_RXSTART, ST_RXDIR, ST_RXIDX, ST_RXDATA}),
    .din(line_q), .crc(rx_crc)
  );

  sdcmd_capture #(.W(IDX_W)) u_idx_cap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(state == ST_RXIDX),
    .din(line_q), .q(resp_index)
  );

  sdcmd_capture #(.W(LONG_W)) u_data_cap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(state == ST_RXDATA),
    .din(line_q), .q(resp_payload)
  );

  sdcmd_capture #(.W(CRC_W)) u_crc_cap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(state == ST_RXCRC),
    .din(line_q), .q(rcv_crc)
  );

  assign cmd_ready   = (state == ST_IDLE);
  assign resp_done   = done_q;
  assign err_crc     = err_crc_q;
  assign err_timeout = err_to_q;
  assign fsm_state   = state;

  // R2
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (fsm_state == ST_INIT || fsm_state == ST_TXSTART));

  // R4
  tx_start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TXSTART) |=> (state == ST_TXDIR && cmd_line_out));

  // R4
  tx_dir_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TXDIR) |=> (state == ST_TXBODY));

  // R6
  tx_end_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TXEND) |=> (state == ST_TURN || state == ST_GAP));

  // R8
  timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> ($past(state) == ST_TURN));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == ST_RXEND || state == ST_TURN || accept) |=> ($stable(err_crc) && $stable(err_timeout)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  // R13
  no_irq_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_state != ST_RXIRQ);

endmodule

// File: tb/sdcmd_path_test.sv
module sdcmd_path_test;

  localparam time CLK_P = 20ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic         cmd_resp_en = 1'b0;
  logic         cmd_resp_long = 1'b0;
  logic         cmd_line_in = 1'b1;
  logic         cmd_line_out, cmd_line_oe;
  logic [5:0]   resp_index;
  logic [119:0] resp_payload;
  logic         resp_done, err_crc, err_timeout;
  logic [3:0]   fsm_state;

  int  tests = 0;
  int  fails = 0;
  bit  inited = 1'b0;
  bit  ended = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sdcmd_path uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_resp_en(cmd_resp_en),
    .cmd_resp_long(cmd_resp_long), .cmd_line_in(cmd_line_in),
    .cmd_line_out(cmd_line_out), .cmd_line_oe(cmd_line_oe),
    .resp_index(resp_index), .resp_payload(resp_payload), .resp_done(resp_done),
    .err_crc(err_crc), .err_timeout(err_timeout), .fsm_state(fsm_state)
  );

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7q(input bit q[$]);
    logic [6:0] c = '0;
    foreach (q[i]) begin
      logic fb = q[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3, 4, 5, 6: return "R4";
      14: return "R6";
      15: return "R7";
      default: return "R9";
    endcase
  endfunction

  // dly: 0 means the card never answers, otherwise turnaround cycles until the start bit is seen
  task automatic run_cmd(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                         input bit resp, input bit lng, input int dly,
                         input logic [5:0] ridx, input logic [119:0] rdata,
                         input bit crc_bad, input bit end_bad,
                         input bit exp_crc_err, input bit exp_to_err);
    int es[$];
    bit eo[$], ee[$], ed[$], drv[$], fr[$], rb[$];
    logic [6:0] c;
    int w0, nd, bad_t;
    bit trace_ok;
    string bad_msg;

    es.push_back(0); eo.push_back(1); ee.push_back(0); ed.push_back(0);
    if (!inited)
      for (int i = 0; i < 74; i++) begin es.push_back(1); eo.push_back(1); ee.push_back(1); ed.push_back(0); end
    fr.push_back(0); fr.push_back(1);
    for (int i = 5; i >= 0; i--) fr.push_back(idx[i]);
    for (int i = 31; i >= 0; i--) fr.push_back(arg[i]);
    c = crc7q(fr);
    es.push_back(2); eo.push_back(0); ee.push_back(1); ed.push_back(0);
    es.push_back(3); eo.push_back(1); ee.push_back(1); ed.push_back(0);
    for (int i = 2; i < 40; i++) begin es.push_back(4); eo.push_back(fr[i]); ee.push_back(1); ed.push_back(0); end
    for (int i = 6; i >= 0; i--) begin es.push_back(5); eo.push_back(c[i]); ee.push_back(1); ed.push_back(0); end
    es.push_back(6); eo.push_back(1); ee.push_back(1); ed.push_back(0);

    w0 = es.size();
    if (resp) begin
      int turn_n = (dly == 0) ? 64 : dly;
      for (int i = 0; i < turn_n; i++) begin es.push_back(15); eo.push_back(1); ee.push_back(0); ed.push_back(0); end
      if (dly != 0) begin
        nd = lng ? 120 : 32;
        rb.push_back(0); es.push_back(7);
        rb.push_back(0); es.push_back(9);
        for (int i = 5; i >= 0; i--) begin rb.push_back(ridx[i]); es.push_back(10); end
        for (int i = nd - 1; i >= 0; i--) begin rb.push_back(rdata[i]); es.push_back(11); end
        if (!lng) begin
          logic [6:0] rc = crc7q(rb);
          if (crc_bad) rc[0] = ~rc[0];
          for (int i = 6; i >= 0; i--) begin rb.push_back(rc[i]); es.push_back(12); end
        end
        rb.push_back(!end_bad); es.push_back(13);
        while (eo.size() < es.size()) begin eo.push_back(1); ee.push_back(0); ed.push_back(0); end
      end
    end
    for (int i = 0; i < 8; i++) begin
      es.push_back(14); eo.push_back(1); ee.push_back(1);
      ed.push_back(i == 0 && resp && dly != 0);
    end
    es.push_back(0); eo.push_back(1); ee.push_back(0); ed.push_back(0);

    for (int i = 0; i < es.size(); i++) drv.push_back(1);
    foreach (rb[j]) drv[w0 + dly - 1 + j] = rb[j];

    trace_ok = 1'b1;
    bad_t = 0;
    bad_msg = "";
    for (int t = 0; t < es.size(); t++) begin
      if (t > 0) @(negedge clk);
      if (t == 0) begin
        cmd_index = idx; cmd_arg = arg; cmd_resp_en = resp; cmd_resp_long = lng; cmd_valid = 1'b1;
      end else if (t == 1) begin
        cmd_valid = 1'b0; cmd_index = ~idx; cmd_arg = ~arg; cmd_resp_en = ~resp; cmd_resp_long = ~lng;
      end
      if (trace_ok && (fsm_state !== es[t][3:0] || cmd_line_out !== eo[t] || cmd_line_oe !== ee[t]
                       || cmd_ready !== (es[t] == 0) || resp_done !== ed[t])) begin
        trace_ok = 1'b0;
        bad_t = t;
        bad_msg = $sformatf("%s cycle %0d state/out/oe/ready/done actual %0d/%0b/%0b/%0b/%0b expected %0d/%0b/%0b/%0b/%0b",
          (resp_done !== ed[t]) ? "R12" : req_of(es[t]), t, fsm_state, cmd_line_out, cmd_line_oe,
          cmd_ready, resp_done, es[t], eo[t], ee[t], (es[t] == 0), ed[t]);
      end
      cmd_line_in = drv[t];
    end
    inited = 1'b1;

    tests++;
    if (!trace_ok) begin
      fails++;
      $display("FAIL %s trace %s (first bad cycle %0d)", tag, bad_msg, bad_t);
    end
    check("R11", {tag, " err_crc"}, 128'(err_crc), 128'(exp_crc_err));
    check("R8", {tag, " err_timeout"}, 128'(err_timeout), 128'(exp_to_err));
    if (resp && dly != 0) begin
      check("R9", {tag, " resp_index"}, 128'(resp_index), 128'(ridx));
      check(lng ? "R10" : "R9", {tag, " resp_payload"}, 128'(resp_payload),
            lng ? 128'(rdata) : 128'(rdata[31:0]));
    end else begin
      check("R2", {tag, " resp_index cleared"}, 128'(resp_index), 128'(0));
      check("R2", {tag, " resp_payload cleared"}, 128'(resp_payload), 128'(0));
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "fsm_state", 128'(fsm_state), 128'(0));
    check("R1", "cmd_line_oe", 128'(cmd_line_oe), 128'(0));
    check("R1", "cmd_line_out", 128'(cmd_line_out), 128'(1));
    check("R1", "cmd_ready", 128'(cmd_ready), 128'(1));
    check("R1", "errors", 128'({err_crc, err_timeout, resp_done}), 128'(0));

    // R3 R5 R6: first command, with init sequence, no response
    run_cmd("no-resp init", 6'd0, 32'h0, 0, 0, 0, '0, '0, 0, 0, 0, 0);
    // R9 short response, start bit after 5 turnaround cycles
    run_cmd("short ok", 6'd17, 32'h1234_5678, 1, 0, 5, 6'd17, 120'hA5C3_0F96, 0, 0, 0, 0);
    // R11 corrupted CRC
    run_cmd("short badcrc", 6'd13, 32'hDEAD_BEEF, 1, 0, 2, 6'd13, 120'h0000_FFFF, 1, 0, 1, 0);
    // R11 flags clear on next command; R7 start bit in the first turnaround cycle
    run_cmd("short dly1", 6'd55, 32'h8000_0001, 1, 0, 1, 6'd55, 120'h7FFF_FFFE, 0, 0, 0, 0);
    // R11 wrong index echo
    run_cmd("short badidx", 6'd17, 32'h0000_0200, 1, 0, 4, 6'd18, 120'h1111_2222, 0, 0, 1, 0);
    // R11 end bit low
    run_cmd("short badend", 6'd7, 32'hCAFE_0000, 1, 0, 3, 6'd7, 120'h0F0F_0F0F, 0, 1, 1, 0);
    // R10 long response, foreign index echo is not checked
    run_cmd("long ok", 6'd2, 32'h0, 1, 1, 3, 6'd63,
            120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 0, 0, 0, 0);
    // R8 no answer at all
    run_cmd("timeout", 6'd9, 32'h0001_0000, 1, 0, 0, '0, '0, 0, 0, 0, 1);
    // R8 start bit in the 64th turnaround cycle still counts
    run_cmd("dly64", 6'd41, 32'h5555_AAAA, 1, 0, 64, 6'd41, 120'h3C3C_C3C3, 0, 0, 0, 0);
    // R6 R11 a later no-response command clears flags and skips init (R3)
    run_cmd("no-resp later", 6'd12, 32'hFFFF_FFFF, 0, 0, 0, '0, '0, 0, 0, 0, 0);

    finish_run();
  end

endmodule